// File: doc/BRIEF.md
# Sensor Readout Frame and Line Timing Generator

This block paces the readout of a pixel-array sensor. A column counter steps through the clocks of one row, and a row counter steps through the rows of one frame. From these two counters it drives a frame sync, a line sync and a data-valid strobe. Each sync has its own output polarity. A column index stands in for the pixel data bus. The row period is the active column count plus a horizontal blanking interval that follows the active columns. A frame holds, in this order, the active rows, the dark (optically black) rows and the vertical blanking rows.

The configuration arrives on plain register inputs. The block samples all of it in one step at the start of each frame, so a frame never mixes two settings. The active-row input is programmed as the row count minus one. A dark-row count below four is raised to four. The block also times an exposure in whole row periods. It pulses a flag when the exposure ends. When the requested exposure is longer than the frame, it clamps the exposure and raises an error flag.

Top module: `sensor_readout_timer`

## Requirements
- R1: The row period L is cfg_act_cols + cfg_hblank clocks. The sum saturates at 2^COL_W-1 (4095 by default), and a sum of zero gives a period of 1 clock.
- R2: A frame has T = (cfg_act_rows_m1 + 1) + D + cfg_vblank rows, where D is the effective dark-row count. The time between two successive starts of active vsync is exactly T*L clocks.
- R3: The effective dark-row count D is cfg_dark_rows, raised to 4 when cfg_dark_rows is below 4.
- R4: vsync is active for exactly the first row of each frame, which is L clocks per frame.
- R5: hsync is active for the first cfg_act_cols clocks of every row of the frame, including dark and blanking rows. This gives cfg_act_cols*T active clocks per frame.
- R6: data_valid is 1 only during the active columns of the first cfg_act_rows_m1+1 rows, which gives cfg_act_cols*(cfg_act_rows_m1+1) clocks per frame. While it is 1, pix_col counts from 0 to cfg_act_cols-1 within each row.
- R7: Each sync output equals its active level XOR its polarity bit. With cfg_pol_hsync=1 or cfg_pol_vsync=1 that output is active-low.
- R8: With E = cfg_expo_rows in the range 1..T, expo_done is a one-clock pulse, once per frame, E*L-1 clocks after the first active vsync clock. With E = 0 it never pulses.
- R9: When cfg_expo_rows is greater than T, the exposure is clamped to T and expo_err is 1 for that whole frame. Otherwise expo_err is 0.
- R10: A configuration change made in the middle of a frame has no effect on that frame. It takes effect from the next frame.
- R11: While rst is 1, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_act_rows_m1 | input | ROW_W | Active rows minus one |
| cfg_act_cols | input | COL_W | Active columns per row |
| cfg_hblank | input | COL_W | Horizontal blanking clocks at the end of each row |
| cfg_vblank | input | ROW_W | Vertical blanking rows |
| cfg_dark_rows | input | DARK_W | Dark rows (minimum 4) |
| cfg_expo_rows | input | EXP_W | Exposure length in row periods |
| cfg_pol_hsync | input | 1 | 1 makes hsync active-low |
| cfg_pol_vsync | input | 1 | 1 makes vsync active-low |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| data_valid | output | 1 | Active pixel strobe |
| pix_col | output | COL_W | Column index of the current clock |
| expo_done | output | 1 | Exposure-end pulse |
| expo_err | output | 1 | Exposure request exceeded the frame length |

## Verification
The bench measures whole frames and compares the frame length, the vsync, hsync and data-valid totals and the exposure pulse position against closed-form values. Directed frames separate the three row regions by giving them unequal sizes. A dark count below four shows whether the minimum is applied. A zero exposure, an exposure longer than the frame, a saturating row period and a zero row period probe the arithmetic edges. Randomized frames with mixed polarities cover combinations of these, and a change made in the middle of a frame shows whether the new settings wait until the next frame starts.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [1:0] {RG_ACTIVE, RG_DARK, RG_VBLANK} row_region_e;
  localparam int unsigned MIN_DARK = 4;
endpackage

// File: rtl/srt_cfg_latch.sv
module srt_cfg_latch import srt_pkg::*; #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 12,
  parameter int DARK_W = 4,
  parameter int EXP_W  = 12,
  parameter int TOT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ROW_W-1:0]  act_rows_m1,
  input  logic [COL_W-1:0]  act_cols,
  input  logic [COL_W-1:0]  hblank,
  input  logic [ROW_W-1:0]  vblank,
  input  logic [DARK_W-1:0] dark_rows,
  input  logic [EXP_W-1:0]  expo_rows,
  input  logic              pol_h,
  input  logic              pol_v,
  output logic [TOT_W-1:0]  q_act_rows,
  output logic [TOT_W-1:0]  q_dark_end,
  output logic [TOT_W-1:0]  q_tot_rows,
  output logic [COL_W-1:0]  q_act_cols,
  output logic [COL_W-1:0]  q_row_len,
  output logic [TOT_W-1:0]  q_expo_rows,
  output logic              q_expo_err,
  output logic              q_pol_h,
  output logic              q_pol_v
);
  localparam int CMP_W = (EXP_W > TOT_W) ? EXP_W : TOT_W;
  localparam logic [COL_W:0] LEN_MAX = {1'b0, {COL_W{1'b1}}};

  logic [COL_W:0]   len_sum;
  logic [COL_W-1:0] len_n;
  logic [TOT_W-1:0] dark_n, act_n, dark_end_n, tot_n, expo_n;
  logic             err_n;

  always_comb begin
    len_sum = {1'b0, act_cols} + {1'b0, hblank};
    if (len_sum > LEN_MAX)   len_n = LEN_MAX[COL_W-1:0];
    else if (len_sum == '0)  len_n = COL_W'(1);
    else                     len_n = len_sum[COL_W-1:0];

    if (TOT_W'(dark_rows) < TOT_W'(MIN_DARK)) dark_n = TOT_W'(MIN_DARK);
    else                                      dark_n = TOT_W'(dark_rows);

    act_n      = TOT_W'(act_rows_m1) + TOT_W'(1);
    dark_end_n = act_n + dark_n;
    tot_n      = dark_end_n + TOT_W'(vblank);

    err_n  = CMP_W'(expo_rows) > CMP_W'(tot_n);
    expo_n = err_n ? tot_n : TOT_W'(expo_rows);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_act_rows  <= '0;
      q_dark_end  <= '0;
      q_tot_rows  <= '0;
      q_act_cols  <= '0;
      q_row_len   <= '0;
      q_expo_rows <= '0;
      q_expo_err  <= 1'b0;
      q_pol_h     <= 1'b0;
      q_pol_v     <= 1'b0;
    end else if (load) begin
      q_act_rows  <= act_n;
      q_dark_end  <= dark_end_n;
      q_tot_rows  <= tot_n;
      q_act_cols  <= act_cols;
      q_row_len   <= len_n;
      q_expo_rows <= expo_n;
      q_expo_err  <= err_n;
      q_pol_h     <= pol_h;
      q_pol_v     <= pol_v;
    end
  end
endmodule

// File: rtl/srt_scan.sv
module srt_scan #(
  parameter int COL_W = 12,
  parameter int TOT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] row_len,
  input  logic [TOT_W-1:0] tot_rows,
  output logic [COL_W-1:0] col,
  output logic [TOT_W-1:0] row,
  output logic             primed,
  output logic             row_end,
  output logic             load
);
  always_comb begin
    row_end = primed && (col == row_len - COL_W'(1));
    load    = !primed || (row_end && (row == tot_rows - TOT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col    <= '0;
      row    <= '0;
      primed <= 1'b0;
    end else if (load) begin
      col    <= '0;
      row    <= '0;
      primed <= 1'b1;
    end else if (row_end) begin
      col <= '0;
      row <= row + TOT_W'(1);
    end else begin
      col <= col + COL_W'(1);
    end
  end
endmodule

// File: rtl/srt_out.sv
module srt_out import srt_pkg::*; #(
  parameter int COL_W = 12,
  parameter int TOT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             primed,
  input  logic             row_end,
  input  logic [COL_W-1:0] col,
  input  logic [TOT_W-1:0] row,
  input  logic [TOT_W-1:0] act_rows,
  input  logic [TOT_W-1:0] dark_end,
  input  logic [COL_W-1:0] act_cols,
  input  logic [TOT_W-1:0] expo_rows,
  input  logic             pol_h,
  input  logic             pol_v,
  output logic             hsync,
  output logic             vsync,
  output logic             data_valid,
  output logic [COL_W-1:0] pix_col,
  output logic             expo_done
);
  row_region_e region;
  logic        hs_act, vs_act, expo_hit;

  always_comb begin
    if (row < act_rows)      region = RG_ACTIVE;
    else if (row < dark_end) region = RG_DARK;
    else                     region = RG_VBLANK;
    hs_act   = primed && (col < act_cols);
    vs_act   = primed && (row == '0);
    expo_hit = row_end && (expo_rows != '0) && (row == expo_rows - TOT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync      <= 1'b0;
      vsync      <= 1'b0;
      data_valid <= 1'b0;
      pix_col    <= '0;
      expo_done  <= 1'b0;
    end else begin
      hsync      <= pol_h ^ hs_act;
      vsync      <= pol_v ^ vs_act;
      data_valid <= hs_act && (region == RG_ACTIVE);
      pix_col    <= col;
      expo_done  <= expo_hit;
    end
  end
endmodule

// File: rtl/sensor_readout_timer.sv
module sensor_readout_timer #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 12,
  parameter int DARK_W = 4,
  parameter int EXP_W  = ROW_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROW_W-1:0]  cfg_act_rows_m1,
  input  logic [COL_W-1:0]  cfg_act_cols,
  input  logic [COL_W-1:0]  cfg_hblank,
  input  logic [ROW_W-1:0]  cfg_vblank,
  input  logic [DARK_W-1:0] cfg_dark_rows,
  input  logic [EXP_W-1:0]  cfg_expo_rows,
  input  logic              cfg_pol_hsync,
  input  logic              cfg_pol_vsync,
  output logic              hsync,
  output logic              vsync,
  output logic              data_valid,
  output logic [COL_W-1:0]  pix_col,
  output logic              expo_done,
  output logic              expo_err
);
  localparam int TOT_W = ROW_W + 2;

  logic [TOT_W-1:0] q_act_rows, q_dark_end, q_tot_rows, q_expo_rows;
  logic [COL_W-1:0] q_act_cols, q_row_len;
  logic             q_pol_h, q_pol_v;
  logic [COL_W-1:0] scan_col;
  logic [TOT_W-1:0] scan_row;
  logic             scan_primed, scan_row_end, scan_load;

  srt_cfg_latch #(.ROW_W(ROW_W), .COL_W(COL_W), .DARK_W(DARK_W),
                  .EXP_W(EXP_W), .TOT_W(TOT_W)) u_cfg (
    .clk(clk), .rst(rst), .load(scan_load),
    .act_rows_m1(cfg_act_rows_m1), .act_cols(cfg_act_cols),
    .hblank(cfg_hblank), .vblank(cfg_vblank), .dark_rows(cfg_dark_rows),
    .expo_rows(cfg_expo_rows), .pol_h(cfg_pol_hsync), .pol_v(cfg_pol_vsync),
    .q_act_rows(q_act_rows), .q_dark_end(q_dark_end), .q_tot_rows(q_tot_rows),
    .q_act_cols(q_act_cols), .q_row_len(q_row_len), .q_expo_rows(q_expo_rows),
    .q_expo_err(expo_err), .q_pol_h(q_pol_h), .q_pol_v(q_pol_v)
  );

  srt_scan #(.COL_W(COL_W), .TOT_W(TOT_W)) u_scan (
    .clk(clk), .rst(rst), .row_len(q_row_len), .tot_rows(q_tot_rows),
    .col(scan_col), .row(scan_row), .primed(scan_primed),
    .row_end(scan_row_end), .load(scan_load)
  );

  srt_out #(.COL_W(COL_W), .TOT_W(TOT_W)) u_out (
    .clk(clk), .rst(rst), .primed(scan_primed), .row_end(scan_row_end),
    .col(scan_col), .row(scan_row), .act_rows(q_act_rows),
    .dark_end(q_dark_end), .act_cols(q_act_cols), .expo_rows(q_expo_rows),
    .pol_h(q_pol_h), .pol_v(q_pol_v),
    .hsync(hsync), .vsync(vsync), .data_valid(data_valid),
    .pix_col(pix_col), .expo_done(expo_done)
  );
endmodule

// File: rtl/srt_chk.sv
module srt_chk #(
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             hsync,
  input logic             data_valid,
  input logic [COL_W-1:0] pix_col,
  input logic             expo_err,
  input logic             load,
  input logic             pol_h,
  input logic [COL_W-1:0] act_cols
);
  // R6
  dv_inside_hsync_chk: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (hsync != pol_h));

  // R6
  dv_col_bound_chk: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (pix_col < act_cols));

  // R6
  dv_col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (data_valid && $past(data_valid) && pix_col != '0)
      |-> (pix_col == $past(pix_col) + COL_W'(1)));

  // R9
  expo_err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(expo_err));
endmodule

bind sensor_readout_timer srt_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .data_valid(data_valid),
  .pix_col(pix_col), .expo_err(expo_err), .load(scan_load),
  .pol_h(q_pol_h), .act_cols(q_act_cols)
);

// File: tb/sensor_readout_timer_tb.sv
module sensor_readout_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 10, COL_W = 12, DARK_W = 4, EXP_W = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic [ROW_W-1:0]  cfg_act_rows_m1 = '0;
  logic [COL_W-1:0]  cfg_act_cols = '0, cfg_hblank = '0;
  logic [ROW_W-1:0]  cfg_vblank = '0;
  logic [DARK_W-1:0] cfg_dark_rows = '0;
  logic [EXP_W-1:0]  cfg_expo_rows = '0;
  logic cfg_pol_hsync = 1'b0, cfg_pol_vsync = 1'b0;
  logic hsync, vsync, data_valid, expo_done, expo_err;
  logic [COL_W-1:0] pix_col;

  int n_run = 0, n_fail = 0;
  int m_len, m_vs, m_hs, m_dv, m_exp_cnt, m_exp_at, m_first_col, m_last_col, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_readout_timer #(.ROW_W(ROW_W), .COL_W(COL_W), .DARK_W(DARK_W), .EXP_W(EXP_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_act_rows_m1(cfg_act_rows_m1), .cfg_act_cols(cfg_act_cols),
    .cfg_hblank(cfg_hblank), .cfg_vblank(cfg_vblank), .cfg_dark_rows(cfg_dark_rows),
    .cfg_expo_rows(cfg_expo_rows), .cfg_pol_hsync(cfg_pol_hsync), .cfg_pol_vsync(cfg_pol_vsync),
    .hsync(hsync), .vsync(vsync), .data_valid(data_valid), .pix_col(pix_col),
    .expo_done(expo_done), .expo_err(expo_err)
  );

  function automatic int f_len(int cols, int hb);
    int s = cols + hb;
    if (s > 4095) return 4095;
    if (s == 0) return 1;
    return s;
  endfunction
  function automatic int f_total(int m1, int d, int v);
    return (m1 + 1) + ((d < 4) ? 4 : d) + v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit vs_act(); return vsync ^ cfg_pol_vsync; endfunction
  function automatic bit hs_act(); return hsync ^ cfg_pol_hsync; endfunction

  task automatic wait_edge();
    bit prev, cur;
    @(negedge clk);
    prev = vs_act();
    forever begin
      @(negedge clk);
      cur = vs_act();
      if (cur && !prev) break;
      prev = cur;
    end
  endtask

  // Called on the first active vsync sample; returns on the next frame's first one.
  task automatic measure();
    bit prev, cur;
    m_len = 0; m_vs = 0; m_hs = 0; m_dv = 0; m_exp_cnt = 0; m_exp_at = -1;
    m_first_col = -1; m_last_col = -1; m_err = int'(expo_err);
    cur = vs_act();
    forever begin
      if (cur) m_vs++;
      if (hs_act()) m_hs++;
      if (data_valid) begin
        m_dv++;
        if (m_first_col < 0) m_first_col = int'(pix_col);
        m_last_col = int'(pix_col);
      end
      if (expo_done) begin m_exp_cnt++; m_exp_at = m_len; end
      m_len++;
      prev = cur;
      @(negedge clk);
      cur = vs_act();
      if (cur && !prev) break;
    end
  endtask

  task automatic check_frame(int m1, int cols, int hb, int v, int d, int e);
    int rl = f_len(cols, hb);
    int tot = f_total(m1, d, v);
    int ee = (e > tot) ? tot : e;
    chk(m_len == tot * rl, "R2 frame period", m_len, tot * rl);
    chk(m_vs == rl, "R4 vsync width", m_vs, rl);
    chk(m_hs == cols * tot, "R5 hsync clocks", m_hs, cols * tot);
    chk(m_dv == cols * (m1 + 1), "R6 data_valid clocks", m_dv, cols * (m1 + 1));
    if (cols > 0) begin
      chk(m_first_col == 0, "R6 first column", m_first_col, 0);
      chk(m_last_col == cols - 1, "R6 last column", m_last_col, cols - 1);
    end
    chk(m_exp_cnt == ((ee == 0) ? 0 : 1), "R8 expo pulse count", m_exp_cnt, (ee == 0) ? 0 : 1);
    if (ee != 0) chk(m_exp_at == ee * rl - 1, "R8 expo position", m_exp_at, ee * rl - 1);
    chk(m_err == ((e > tot) ? 1 : 0), "R9 expo_err", m_err, (e > tot) ? 1 : 0);
  endtask

  task automatic setup(int m1, int cols, int hb, int v, int d, int e, bit ph, bit pv);
    cfg_act_rows_m1 = ROW_W'(m1); cfg_act_cols = COL_W'(cols); cfg_hblank = COL_W'(hb);
    cfg_vblank = ROW_W'(v); cfg_dark_rows = DARK_W'(d); cfg_expo_rows = EXP_W'(e);
    cfg_pol_hsync = ph; cfg_pol_vsync = pv;
  endtask

  task automatic run_case(int m1, int cols, int hb, int v, int d, int e, bit ph, bit pv);
    @(negedge clk);
    rst = 1'b1;
    setup(m1, cols, hb, v, d, e, ph, pv);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_edge();
    measure();
    check_frame(m1, cols, hb, v, d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    // R11 outputs quiet during reset, even with inverted polarity
    setup(3, 6, 4, 2, 4, 3, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk({hsync, vsync, data_valid, expo_done, expo_err} == 5'b0 && pix_col == '0,
        "R11 reset outputs", int'({hsync, vsync, data_valid, expo_done, expo_err}), 0);

    // R1 R2 basic directed frame
    run_case(3, 6, 4, 2, 4, 3, 1'b0, 1'b0);
    // R3 dark count below four
    run_case(2, 5, 3, 1, 1, 2, 1'b0, 1'b0);
    run_case(0, 4, 0, 0, 0, 5, 1'b0, 1'b0);
    // R7 inverted polarity, R8 zero exposure
    run_case(4, 7, 2, 3, 6, 0, 1'b1, 1'b1);
    // R9 exposure longer than frame
    run_case(1, 3, 2, 1, 4, 50, 1'b0, 1'b1);
    // R1 zero row period and saturated row period
    run_case(1, 0, 0, 2, 5, 1, 1'b0, 0);
    run_case(0, 4000, 200, 0, 4, 5, 1'b1, 1'b0);

    // R10 mid-frame change waits for next frame
    @(negedge clk);
    rst = 1'b1;
    setup(3, 6, 4, 2, 4, 3, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_edge();
    fork
      measure();
      begin
        repeat (40) @(negedge clk);
        setup(1, 3, 2, 0, 5, 2, 1'b0, 1'b0);
      end
    join
    chk(m_len == 100, "R10 current frame keeps old settings", m_len, 100);
    measure();
    check_frame(1, 3, 2, 0, 5, 2);
    chk(m_len == f_total(1, 5, 0) * 5, "R10 next frame uses new settings", m_len, f_total(1, 5, 0) * 5);

    // Random frames
    for (int i = 0; i < 20; i++) begin
      int m1 = int'($urandom_range(7, 0));
      int cols = int'($urandom_range(15, 0));
      int hb = int'($urandom_range(7, 0));
      int v = int'($urandom_range(5, 0));
      int d = int'($urandom_range(7, 0));
      int e = int'($urandom_range(25, 0));
      run_case(m1, cols, hb, v, d, e, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule